// File: doc/BRIEF.md
# Filtered Reset Sequencer

This block turns a noisy, active-low external reset line into a clean internal reset for a small microcontroller core. The raw line is first passed through a synchroniser. A filter then requires it to stay low for a minimum number of consecutive clock samples before anything happens, so short glitches are ignored.

Once the line qualifies, the block raises the core reset. It keeps that reset up for a fixed minimum number of cycles, or for as long as the external line stays low, whichever is longer. During reset it overrides the external bus strobes: the data strobe is held low and the address strobe toggles every clock.

When reset ends, it pulses a one-cycle load request. Alongside that request it presents the program-counter start vector, so the core begins fetching from a fixed address.

Top module: `reset_sequencer`

## Requirements
- R1: After the block's own reset `rst_ni`, `core_rst_o` is 0, `ds_n_o` is 1, `as_n_o` is 1, `pc_load_o` is 0 and `start_vec_o` reads 0x000C.
- R2: An external low of fewer than FILT_CYC (4) clock samples raises no internal reset; this includes a single-cycle low.
- R3: The filter count restarts whenever the synchronised line returns high. Two 3-clock lows separated by one high clock raise no reset.
- R4: `core_rst_o` first reads high 7 clocks after the rising edge at which the external line is first sampled low (two synchroniser stages, four filter samples, one latch). A low of exactly 4 clocks qualifies.
- R5: For a qualifying low of L clocks, `core_rst_o` stays high for max(HOLD_CYC, L-4) cycles, with HOLD_CYC = 18.
- R6: `ds_n_o` is 0 in every cycle where `core_rst_o` is 1, and 1 otherwise.
- R7: `as_n_o` is 0 in the first reset cycle and inverts in every following reset cycle; it is 1 outside reset.
- R8: `pc_load_o` is 1 for exactly the one cycle after `core_rst_o` falls, and 0 at all other times. `start_vec_o` holds START_VEC (0x000C).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the sequencer itself |
| ext_rst_ni | input | 1 | Raw external reset line, active low, asynchronous |
| core_rst_o | output | 1 | Internal reset to the core, active high |
| ds_n_o | output | 1 | Data-strobe override, low during reset |
| as_n_o | output | 1 | Address-strobe override, toggling during reset |
| pc_load_o | output | 1 | One-cycle request to load the start vector |
| start_vec_o | output | VEC_W (16) | Program-counter start vector |

## Verification
The bench uses the default parameters: FILT_CYC = 4, HOLD_CYC = 18 and a 16-bit vector of 0x000C. With these values every edge of the filter and the stretch is reachable in a few dozen cycles.

The stimulus includes single-clock and three-clock glitches, a glitch pair that would qualify if the filter count carried over, and a low of exactly the threshold. It also includes lows around the L = 22 crossover, where the stretch switches from the fixed count to following the external line. For each of these the bench measures the assertion latency, the width of the reset and the strobe pattern.

// File: rtl/reset_seq_pkg.sv
package reset_seq_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_HOLD = 1'b1
  } seq_state_e;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[i] <= 1'b1;
        else if (i == 0) chain_q[i] <= d_i;
        else chain_q[i] <= chain_q[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsq_filter.sv
module rsq_filter #(
  parameter int FILT_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_i,
  output logic qual_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [CW-1:0] cnt_q;

  // consecutive low samples, saturating; any high sample restarts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!low_i) cnt_q <= '0;
    else if (cnt_q != CW'(FILT_CYC)) cnt_q <= cnt_q + CW'(1);
  end

  assign qual_o = (cnt_q == CW'(FILT_CYC));

  a_r2_qual_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_o |-> $past(low_i));
endmodule

// File: rtl/rsq_stretch.sv
module rsq_stretch
  import reset_seq_pkg::*;
#(
  parameter int HOLD_CYC = 18
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic qual_i,
  input  logic low_i,
  output logic rst_nxt_o,
  output logic rel_nxt_o,
  output logic rst_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  seq_state_e    st_q, st_d;
  logic [HW-1:0] hold_q, hold_d;
  logic          rel;

  always_comb begin
    st_d   = st_q;
    hold_d = hold_q;
    rel    = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (qual_i) begin
          st_d   = SEQ_HOLD;
          hold_d = HW'(1);
        end
      end
      SEQ_HOLD: begin
        // leave only after the minimum count and with the line released
        if (hold_q >= HW'(HOLD_CYC) && !low_i) begin
          st_d   = SEQ_IDLE;
          hold_d = '0;
          rel    = 1'b1;
        end else if (hold_q < HW'(HOLD_CYC)) begin
          hold_d = hold_q + HW'(1);
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEQ_IDLE;
      hold_q <= '0;
    end else begin
      st_q   <= st_d;
      hold_q <= hold_d;
    end
  end

  assign rst_nxt_o = (st_d == SEQ_HOLD);
  assign rel_nxt_o = rel;
  assign rst_o     = (st_q == SEQ_HOLD);

  a_r4_rise_needs_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_o) |-> $past(qual_i));
  a_r5_release_needs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> $past(!low_i));
endmodule

// File: rtl/rsq_strobe.sv
module rsq_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_nxt_i,
  input  logic rel_nxt_i,
  input  logic rst_i,
  output logic ds_n_o,
  output logic as_n_o,
  output logic pc_load_o
);
  logic ds_q, as_q, pl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ds_q <= 1'b1;
      as_q <= 1'b1;
      pl_q <= 1'b0;
    end else begin
      ds_q <= !rst_nxt_i;
      as_q <= rst_nxt_i ? !as_q : 1'b1;
      pl_q <= rel_nxt_i;
    end
  end

  assign ds_n_o    = ds_q;
  assign as_n_o    = as_q;
  assign pc_load_o = pl_q;

  a_r6_ds_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_i |-> !ds_n_o);
  a_r7_as_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_i && $past(rst_i)) |-> (as_n_o != $past(as_n_o)));
  a_r8_load_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_i) |-> pc_load_o);
  a_r8_load_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !pc_load_o);
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
  parameter int          SYNC_STAGES = 2,
  parameter int          FILT_CYC    = 4,
  parameter int          HOLD_CYC    = 18,
  parameter int          VEC_W       = 16,
  parameter logic [15:0] START_VEC   = 16'h000C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_rst_ni,
  output logic             core_rst_o,
  output logic             ds_n_o,
  output logic             as_n_o,
  output logic             pc_load_o,
  output logic [VEC_W-1:0] start_vec_o
);
  logic sync_q, qual, rst_nxt, rel_nxt, rst_q;

  rsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_rst_ni), .q_o(sync_q)
  );

  rsq_filter #(.FILT_CYC(FILT_CYC)) u_filter (
    .clk_i(clk_i), .rst_ni(rst_ni), .low_i(!sync_q), .qual_o(qual)
  );

  rsq_stretch #(.HOLD_CYC(HOLD_CYC)) u_stretch (
    .clk_i(clk_i), .rst_ni(rst_ni), .qual_i(qual), .low_i(!sync_q),
    .rst_nxt_o(rst_nxt), .rel_nxt_o(rel_nxt), .rst_o(rst_q)
  );

  rsq_strobe u_strobe (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_nxt_i(rst_nxt), .rel_nxt_i(rel_nxt),
    .rst_i(rst_q), .ds_n_o(ds_n_o), .as_n_o(as_n_o), .pc_load_o(pc_load_o)
  );

  assign core_rst_o  = rst_q;
  assign start_vec_o = VEC_W'(START_VEC);

  a_r1_idle_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_rst_o |-> (ds_n_o && as_n_o));
endmodule

// File: tb/reset_sequencer_tb_top.sv
`timescale 1ns/1ps
module reset_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_n = 1'b1;
  logic        core_rst, ds_n, as_n, pc_load;
  logic [15:0] vec;

  int tests = 0, fails = 0, cyc = 0;
  int exp_w_q[$];
  int exp_d_q[$];

  int width = 0, rise_cyc = 0, start_cyc = 0;
  int ds_bad = 0, as_bad = 0, idle_bad = 0, pl_seen = 0, pl_bad = 0;
  logic prev_rst = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  reset_sequencer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_ni(ext_n), .core_rst_o(core_rst),
    .ds_n_o(ds_n), .as_n_o(as_n), .pc_load_o(pc_load), .start_vec_o(vec)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: observes reset pulses and strobe behaviour at negedge
  always @(negedge clk) begin
    if (rst_n) begin
      if (core_rst) begin
        if (width == 0) rise_cyc = cyc;
        if (ds_n !== 1'b0) ds_bad++;
        if (as_n !== ((width % 2) != 0)) as_bad++;
        if (pc_load !== 1'b0) pl_bad++;
        width++;
      end else begin
        if (ds_n !== 1'b1 || as_n !== 1'b1) idle_bad++;
        if (prev_rst) begin
          if (pc_load === 1'b1) pl_seen++;
          else pl_bad++;
        end else if (pc_load !== 1'b0) pl_bad++;
      end
      prev_rst = core_rst;
    end
  end

  task automatic clear_mon();
    width = 0; ds_bad = 0; as_bad = 0; idle_bad = 0; pl_seen = 0; pl_bad = 0;
  endtask

  // scoreboard compare after each window
  task automatic score(input string tag);
    int ew, ed;
    ew = exp_w_q.pop_front();
    ed = exp_d_q.pop_front();
    chk(width == ew, {tag, " R5 width"}, width, ew);
    if (ew == 0) begin
      chk(width == 0, {tag, " R2/R3 no reset"}, width, 0);
    end else begin
      chk(rise_cyc - start_cyc == ed, {tag, " R4 latency"}, rise_cyc - start_cyc, ed);
      chk(ds_bad == 0, {tag, " R6 ds low"}, ds_bad, 0);
      chk(as_bad == 0, {tag, " R7 as toggle"}, as_bad, 0);
      chk(pl_seen == 1, {tag, " R8 load pulse"}, pl_seen, 1);
    end
    chk(idle_bad == 0, {tag, " R6/R7 idle strobes"}, idle_bad, 0);
    chk(pl_bad == 0, {tag, " R8 no stray load"}, pl_bad, 0);
  endtask

  // driver: pushes expected width and latency, then drives the low
  task automatic pulse(input int len, input string tag);
    int w;
    w = (len < 4) ? 0 : ((len - 4 > 18) ? len - 4 : 18);
    exp_w_q.push_back(w);
    exp_d_q.push_back(7);
    @(posedge clk); #1;
    clear_mon();
    start_cyc = cyc;
    ext_n = 1'b0;
    repeat (len) @(posedge clk);
    #1 ext_n = 1'b1;
    repeat (60) @(posedge clk);
    score(tag);
  endtask

  initial begin
    #400000;
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(core_rst === 1'b0, "R1 core_rst", int'(core_rst), 0);
    chk(ds_n === 1'b1, "R1 ds_n", int'(ds_n), 1);
    chk(as_n === 1'b1, "R1 as_n", int'(as_n), 1);
    chk(pc_load === 1'b0, "R1 pc_load", int'(pc_load), 0);
    chk(vec === 16'h000C, "R1/R8 start vector", int'(vec), 12);

    pulse(1, "glitch1");
    pulse(3, "glitch3");
    pulse(4, "exact4");
    pulse(5, "len5");
    pulse(22, "len22");
    pulse(23, "len23");
    pulse(40, "len40");

    // R3: two 3-clock lows split by one high clock
    exp_w_q.push_back(0);
    exp_d_q.push_back(7);
    @(posedge clk); #1;
    clear_mon();
    start_cyc = cyc;
    ext_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 ext_n = 1'b1;
    @(posedge clk);
    #1 ext_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 ext_n = 1'b1;
    repeat (60) @(posedge clk);
    score("R3 split");

    chk(vec === 16'h000C, "R8 start vector end", int'(vec), 12);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule